// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write-side steering logic of a multi-queue FIFO device that holds 32 queues and can be chained with up to seven more identical devices. A single address bus is sampled on the write clock and serves two purposes. With the address-enable input high it changes which queue receives writes. With the flag-strobe input high it chooses the status word to be shown on the flag bus. Each device acts only when the top three address bits equal its configured device identity.

A queue change goes through a pipeline. The queue in use before the change keeps receiving writes on the capture edge and on the edge after it. The new queue receives writes from the second edge after capture onward. The block drives one write strobe per queue, a write data path and a registered status-word select. Queue storage, pointers and flag generation sit outside the block.

Top module: `mq_write_selector`

## Requirements
- R1: After reset no queue is active: every write strobe stays low until a valid queue selection has passed through the pipeline, and the status-word select reads 0.
- R2: With address-enable high, the device field `addr[7:5]` equal to `dev_id` and `cfg_pending` low, a rising edge captures `addr[4:0]` as the new queue. Capture happens whatever the state of the write enables. Writes reach the new queue from the second rising edge after capture.
- R3: On the capture edge and on the edge after it, a write still reaches the queue that was active before the capture. This also holds when selections follow each other on consecutive edges.
- R4: A write strobe is high only when both `wr_en_n` and `wr_cs_n` are low. At most one strobe is high at a time. `q_wr_data` carries `din`.
- R5: A queue selection whose device field differs from `dev_id` is ignored, and the current queue keeps receiving writes.
- R6: While `cfg_pending` is high, queue selections are ignored.
- R7: With flag-strobe high, address-enable low and a matching device field, a rising edge loads `addr[3:0]` into `stat_sel`. Bit 4 plays no part, the write enables are not needed, and a write on that edge still goes to the current queue.
- R8: A status-word selection whose device field differs from `dev_id` leaves `stat_sel` unchanged.
- R9: When address-enable and flag-strobe are both high on an edge, only the queue selection takes effect and `stat_sel` is unchanged.
- R10: Queue n is written through strobe bit n, for n from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pending | input | 1 | High while device configuration is unfinished; blocks queue selection |
| dev_id | input | 3 | Configured identity of this device in a chain |
| addr_en | input | 1 | Queue-address capture enable, active high |
| flag_stb | input | 1 | Status-word select strobe, active high |
| addr | input | 8 | Shared address: [7:5] device, [4:0] queue or [3:0] status word |
| wr_en_n | input | 1 | Write enable, active low |
| wr_cs_n | input | 1 | Write chip select, active low |
| din | input | 36 | Write data |
| q_wr_stb | output | 32 | One write strobe per queue |
| q_wr_data | output | 36 | Write data toward the queues |
| stat_sel | output | 4 | Registered status-word select |

## Verification
The hardest case to reach is a queue selection made on each of two consecutive edges while writes continue. The third edge must still write the first new queue, and only the fourth edge reaches the second. A directed run builds this case on purpose. The random phase also reaches it often, because address-enable is asserted on a large share of cycles. Directed steps cover a device-identity mismatch, selection while configuration is pending and both strobes on one edge. Random addresses put a foreign device field on about a quarter of cycles.

// File: rtl/mq_write_selector.sv
module mq_write_selector #(
  parameter int QN     = 32,
  parameter int DEVW   = 3,
  parameter int DATA_W = 36,
  parameter int STW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_pending,
  input  logic [DEVW-1:0]           dev_id,
  input  logic                      addr_en,
  input  logic                      flag_stb,
  input  logic [DEVW+$clog2(QN)-1:0] addr,
  input  logic                      wr_en_n,
  input  logic                      wr_cs_n,
  input  logic [DATA_W-1:0]         din,
  output logic [QN-1:0]             q_wr_stb,
  output logic [DATA_W-1:0]         q_wr_data,
  output logic [STW-1:0]            stat_sel
);
  localparam int QW = $clog2(QN);
  localparam int AW = DEVW + QW;

  logic          id_hit, q_take, st_take, wr_go;
  logic [QW-1:0] sel_q, act_q;
  logic          sel_vld, act_vld;

  assign id_hit  = addr[AW-1 -: DEVW] == dev_id;
  assign q_take  = addr_en & id_hit & ~cfg_pending;
  assign st_take = flag_stb & ~addr_en & id_hit;
  assign wr_go   = ~wr_en_n & ~wr_cs_n & act_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      sel_vld <= 1'b0;
      act_q   <= '0;
      act_vld <= 1'b0;
    end else begin
      act_q   <= sel_q;
      act_vld <= sel_vld;
      if (q_take) begin
        sel_q   <= addr[QW-1:0];
        sel_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_sel <= '0;
    else if (st_take) stat_sel <= addr[STW-1:0];
  end

  for (genvar i = 0; i < QN; i++) begin : g_stb
    assign q_wr_stb[i] = wr_go & (act_q == QW'(i));
  end

  assign q_wr_data = din;
endmodule

// File: rtl/mq_write_selector_chk.sv
module mq_write_selector_chk #(
  parameter int QN   = 32,
  parameter int DEVW = 3,
  parameter int STW  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_pending,
  input logic [DEVW-1:0]            dev_id,
  input logic                       addr_en,
  input logic                       flag_stb,
  input logic [DEVW+$clog2(QN)-1:0] addr,
  input logic                       wr_en_n,
  input logic                       wr_cs_n,
  input logic [QN-1:0]              q_wr_stb,
  input logic [STW-1:0]             stat_sel,
  input logic [$clog2(QN)-1:0]      sel_q,
  input logic                       sel_vld,
  input logic                       act_vld
);
  localparam int AW = DEVW + $clog2(QN);
  logic hit;
  assign hit = addr[AW-1 -: DEVW] == dev_id;

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_wr_stb));
  assert_strobe_needs_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_wr_stb) |-> (!wr_en_n && !wr_cs_n));
  assert_idle_before_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld |-> (q_wr_stb == '0));
  assert_foreign_queue_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !hit) |=> ($stable(sel_q) && $stable(sel_vld)));
  assert_config_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && cfg_pending) |=> ($stable(sel_q) && $stable(sel_vld)));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && hit && !cfg_pending) |=> (sel_vld && sel_q == $past(addr[AW-DEVW-1:0])));
  assert_status_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_stb && !addr_en && hit) |=> (stat_sel == $past(addr[STW-1:0])));
  assert_foreign_status_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_stb && !hit) |=> $stable(stat_sel));
  assert_queue_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |=> $stable(stat_sel));
endmodule

bind mq_write_selector mq_write_selector_chk #(.QN(QN), .DEVW(DEVW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pending(cfg_pending), .dev_id(dev_id),
  .addr_en(addr_en), .flag_stb(flag_stb), .addr(addr), .wr_en_n(wr_en_n),
  .wr_cs_n(wr_cs_n), .q_wr_stb(q_wr_stb), .stat_sel(stat_sel),
  .sel_q(sel_q), .sel_vld(sel_vld), .act_vld(act_vld));

// File: tb/mq_write_selector_test.sv
module mq_write_selector_test;
  localparam logic [2:0] DEV = 3'd5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfgp = 1'b0, ae = 1'b0, fs = 1'b0, wen = 1'b1, cs = 1'b1;
  logic [7:0]  addr = '0;
  logic [35:0] din = '0;
  logic [31:0] stb;
  logic [35:0] qd;
  logic [3:0]  stat;
  int checks = 0, fails = 0;

  logic [4:0] m_sel, m_act;
  logic       m_selv, m_actv;
  logic [3:0] m_stat;

  always #10 clk = ~clk;

  mq_write_selector uut (
    .clk(clk), .rst_n(rst_n), .cfg_pending(cfgp), .dev_id(DEV),
    .addr_en(ae), .flag_stb(fs), .addr(addr), .wr_en_n(wen), .wr_cs_n(cs),
    .din(din), .q_wr_stb(stb), .q_wr_data(qd), .stat_sel(stat));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= '0; m_act <= '0; m_selv <= 1'b0; m_actv <= 1'b0; m_stat <= '0;
    end else begin
      m_act  <= m_sel;
      m_actv <= m_selv;
      if (ae && addr[7:5] == DEV && !cfgp) begin m_sel <= addr[4:0]; m_selv <= 1'b1; end
      if (fs && !ae && addr[7:5] == DEV) m_stat <= addr[3:0];
    end
  end

  function automatic logic [31:0] exp_stb();
    return (!wen && !cs && m_actv) ? (32'h1 << m_act) : 32'h0;
  endfunction

  function automatic logic [31:0] oh(input int n);
    return 32'h1 << n;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic a_e, input logic f_s, input logic [7:0] a,
                      input logic we, input logic c);
    @(negedge clk);
    ae = a_e; fs = f_s; addr = a; wen = we; cs = c; din = {4'h0, $urandom};
    #2;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 8'h00, 0, 0);
    chk("R1 no strobe after reset", stb, 0);
    chk("R1 status zero", stat, 0);
    step(1, 0, {DEV, 5'd9}, 0, 0);  chk("R1 select edge", stb, 0);
    step(0, 0, 8'h00, 0, 0);        chk("R1 second edge", stb, 0);
    step(0, 0, 8'h00, 0, 0);        chk("R2 new queue 9", stb, oh(9));
    step(1, 0, {DEV, 5'd20}, 0, 0); chk("R3 capture edge old", stb, oh(9));
    step(0, 0, 8'h00, 0, 0);        chk("R3 next edge old", stb, oh(9));
    step(0, 0, 8'h00, 0, 0);        chk("R2 queue 20", stb, oh(20));
    step(1, 0, {DEV, 5'd3}, 0, 0);  chk("R3 b2b first", stb, oh(20));
    step(1, 0, {DEV, 5'd7}, 0, 0);  chk("R3 b2b second", stb, oh(20));
    step(0, 0, 8'h00, 0, 0);        chk("R3 b2b third", stb, oh(3));
    step(0, 0, 8'h00, 0, 0);        chk("R2 b2b fourth", stb, oh(7));
    step(0, 0, 8'h00, 1, 0);        chk("R4 wen high", stb, 0);
    step(0, 0, 8'h00, 0, 1);        chk("R4 cs high", stb, 0);
    chk("R4 data path", qd, din);
    step(1, 0, {3'd2, 5'd1}, 0, 0);
    step(1, 0, {3'd2, 5'd1}, 0, 0);
    step(0, 0, 8'h00, 0, 0);        chk("R5 foreign id ignored", stb, oh(7));
    cfgp = 1'b1;
    step(1, 0, {DEV, 5'd1}, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 0);        chk("R6 blocked while pending", stb, oh(7));
    cfgp = 1'b0;
    step(0, 1, {DEV, 5'h1A}, 0, 0); chk("R7 write on strobe edge", stb, oh(7));
    step(0, 0, 8'h00, 1, 1);        chk("R7 status loaded bit4 ignored", stat, 4'hA);
    step(0, 1, {3'd1, 5'h03}, 1, 1);
    step(0, 0, 8'h00, 1, 1);        chk("R8 foreign status ignored", stat, 4'hA);
    step(1, 1, {DEV, 5'd2}, 1, 1);
    step(0, 0, 8'h00, 1, 1);        chk("R9 status kept", stat, 4'hA);
    step(0, 0, 8'h00, 0, 0);        chk("R9 queue taken", stb, oh(2));
    step(1, 0, {DEV, 5'd31}, 1, 1);
    step(0, 0, 8'h00, 1, 1);
    step(0, 0, 8'h00, 0, 0);        chk("R10 top queue", stb, oh(31));
    step(1, 0, {DEV, 5'd0}, 1, 1);
    step(0, 0, 8'h00, 1, 1);
    step(0, 0, 8'h00, 0, 0);        chk("R10 queue zero", stb, oh(0));

    for (int k = 0; k < 4000; k++) begin
      cfgp = ($urandom % 20) == 0;
      step(($urandom % 4) == 0, ($urandom % 4) == 0,
           {(($urandom % 4) == 0) ? 3'($urandom) : DEV, 5'($urandom)},
           ($urandom % 3) == 0, ($urandom % 4) == 0);
      chk("R3 random routing", stb, exp_stb());
      chk("R7 random status", stat, m_stat);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule